// File: doc/BRIEF.md
# RMII to MII Datapath Bridge

This block sits between a MAC that speaks a 4-bit nibble interface and a PHY that uses the reduced-pin interface with 2-bit data. Both sides run from the one 50 MHz reference clock. The nibble side advances on every second clock. On the transmit path the bridge gives the MAC a sampling strobe on every second clock. It captures the nibble and its enable on that strobe, then sends the nibble as two dibits on the following two clocks, starting with the low dibit.

On the receive path the bridge watches the combined carrier/data-valid line. A frame starts only when that line is high and the dibit equals the preamble code. That dibit becomes the low half of the first nibble, and a slot counter keeps the nibble alignment from then on. Each completed nibble is presented with a one-clock strobe. Carrier sense and data valid are separated from the combined line. Carrier sense falls on the first low sample inside a frame. Data valid stays high while the PHY toggles the line at the frame tail. The collision output is tied inactive and the transmit-error input has no effect.

Top module: `rmii_mii_bridge`

## Requirements
- R1: While rst_n is low, rmii_tx_en, rmii_txd, mii_rx_dv, mii_crs, mii_rx_stb and mii_rxd are all zero.
- R2: mii_tx_stb is high on every second clock after reset and low on the clocks between. The bridge samples mii_tx_en and mii_txd on the clock edge that ends a cycle in which mii_tx_stb is high.
- R3: mii_txd[1:0] of a sampled nibble appears on rmii_txd in the clock after the sampling edge. mii_txd[3:2] appears in the clock after that.
- R4: rmii_tx_en equals the sampled mii_tx_en for both dibit clocks of that nibble, so it is high for exactly two clocks per enabled nibble.
- R5: mii_tx_er has no effect on any output, and mii_col is always 0.
- R6: When idle, a frame starts only on a clock where rmii_crs_dv is 1 and rmii_rxd is 2'b01, and that dibit becomes mii_rxd[1:0] of the first nibble. Any other dibit does not start a frame and leaves mii_rx_dv low, even while rmii_crs_dv is high.
- R7: The edge that samples the second dibit of a nibble loads {second, first} into mii_rxd, raises mii_rx_stb for one clock and sets mii_rx_dv to 1.
- R8: mii_crs is rmii_crs_dv registered by one clock when idle. Inside a frame it falls on the first low sample of rmii_crs_dv and stays low until the frame ends.
- R9: Inside a frame, rmii_crs_dv low on a first-dibit clock does not end the frame. The dibit is kept as data and mii_rx_dv stays 1.
- R10: Inside a frame, rmii_crs_dv low on a second-dibit clock ends the frame. mii_rx_dv goes to 0 on that edge, no strobe is given, the partial nibble is dropped and mii_rxd keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_tx_stb | output | 1 | High in the cycle whose closing edge samples the transmit nibble |
| mii_tx_en | input | 1 | MAC transmit enable |
| mii_txd | input | MII_W | MAC transmit nibble |
| mii_tx_er | input | 1 | MAC transmit error, ignored |
| mii_col | output | 1 | Collision, always 0 |
| mii_crs | output | 1 | Carrier sense |
| mii_rx_dv | output | 1 | Receive data valid |
| mii_rxd | output | MII_W | Received nibble |
| mii_rx_stb | output | 1 | One-clock pulse when a new nibble is on mii_rxd |
| rmii_tx_en | output | 1 | Transmit enable toward the PHY |
| rmii_txd | output | RMII_W | Transmit dibit |
| rmii_crs_dv | input | 1 | Combined carrier sense and data valid from the PHY |
| rmii_rxd | input | RMII_W | Receive dibit |

## Verification
The bench builds the bridge with its default widths: a 4-bit nibble side and a 2-bit line side, which gives two slots per nibble. With two slots every slot is both the first and last position, or next to it, so both halves of the alignment logic are reached on every nibble. That covers the toggling tail, where the low first dibit must be kept as data, and the low second dibit, which must close the frame. Transmit vectors cover enabled and disabled nibbles, with the error input toggled across them.

// File: rtl/rmii_bridge_pkg.sv
package rmii_bridge_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_DATA = 1'b1
    } rx_state_e;

    function automatic int slot_bits(input int ratio);
        return (ratio > 1) ? $clog2(ratio) : 1;
    endfunction

endpackage

// File: rtl/rmii_nibble_phase.sv
module rmii_nibble_phase #(
    parameter int RATIO = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic nib_stb
);
    localparam int PH_W = rmii_bridge_pkg::slot_bits(RATIO);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (ph_q.phase == PH_LAST) begin
            ph_d.phase = '0;
        end else begin
            ph_d.phase = ph_q.phase + PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign nib_stb = (ph_q.phase == '0);

    // R2: a strobe cycle is never followed directly by another
    a_r2_stb_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |=> !nib_stb);

endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer #(
    parameter int MII_W  = 4,
    parameter int RMII_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_stb,
    input  logic              nib_en,
    input  logic [MII_W-1:0]  nib_data,
    output logic              line_en,
    output logic [RMII_W-1:0] line_data
);
    typedef struct packed {
        logic [MII_W-1:0]  sh;
        logic              en;
        logic [RMII_W-1:0] txd;
        logic              txen;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (nib_stb) begin
            tx_d.txd  = nib_data[RMII_W-1:0];
            tx_d.sh   = nib_data >> RMII_W;
            tx_d.en   = nib_en;
            tx_d.txen = nib_en;
        end else begin
            tx_d.txd  = tx_q.sh[RMII_W-1:0];
            tx_d.sh   = tx_q.sh >> RMII_W;
            tx_d.txen = tx_q.en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign line_en   = tx_q.txen;
    assign line_data = tx_q.txd;

    // R3: the low part of the sampled nibble leads
    a_r3_low_dibit_first: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |=> line_data == $past(nib_data[RMII_W-1:0]));

    // R4: enable taken from the MAC on the sampling edge
    a_r4_txen_load: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |=> line_en == $past(nib_en));

    // R4: enable held across the later dibits of the nibble
    a_r4_txen_held: assert property (@(posedge clk) disable iff (!rst_n)
        !nib_stb |=> line_en == $past(line_en));

endmodule

// File: rtl/rmii_rx_deserializer.sv
module rmii_rx_deserializer #(
    parameter int                 MII_W      = 4,
    parameter int                 RMII_W     = 2,
    parameter logic [RMII_W-1:0]  START_CODE = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_crs_dv,
    input  logic [RMII_W-1:0] line_data,
    output logic              nib_crs,
    output logic              nib_dv,
    output logic [MII_W-1:0]  nib_data,
    output logic              nib_stb
);
    import rmii_bridge_pkg::*;

    localparam int RATIO  = MII_W / RMII_W;
    localparam int SLOT_W = slot_bits(RATIO);
    localparam int SH_W   = MII_W - RMII_W;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(RATIO - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [SLOT_W-1:0] slot;
        logic [SH_W-1:0]   sh;
        logic [MII_W-1:0]  nib;
        logic              dv;
        logic              crs;
        logic              stb;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [MII_W-1:0] joined;

    assign joined = {line_data, rx_q.sh};

    always_comb begin
        rx_d     = rx_q;
        rx_d.stb = 1'b0;
        unique case (rx_q.st)
            RX_IDLE: begin
                rx_d.crs = line_crs_dv;
                rx_d.dv  = 1'b0;
                if (line_crs_dv && (line_data == START_CODE)) begin
                    rx_d.st   = RX_DATA;
                    rx_d.sh   = joined[MII_W-1:RMII_W];
                    rx_d.slot = SLOT_W'(1);
                end
            end
            RX_DATA: begin
                rx_d.crs = rx_q.crs & line_crs_dv;
                if (rx_q.slot == SLOT_LAST) begin
                    rx_d.slot = '0;
                    if (line_crs_dv) begin
                        rx_d.nib = joined;
                        rx_d.dv  = 1'b1;
                        rx_d.stb = 1'b1;
                    end else begin
                        rx_d.st  = RX_IDLE;
                        rx_d.dv  = 1'b0;
                        rx_d.crs = 1'b0;
                    end
                end else begin
                    rx_d.sh   = joined[MII_W-1:RMII_W];
                    rx_d.slot = rx_q.slot + SLOT_W'(1);
                end
            end
            default: rx_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{st: RX_IDLE, default: '0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign nib_crs  = rx_q.crs;
    assign nib_dv   = rx_q.dv;
    assign nib_data = rx_q.nib;
    assign nib_stb  = rx_q.stb;

    // R7: a nibble strobe always comes with data valid
    a_r7_stb_with_dv: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |-> nib_dv);

    // R8: carrier sense cannot survive a low sample
    a_r8_crs_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !line_crs_dv |=> !nib_crs);

    // R6: no data valid appears without the combined line
    a_r6_no_spurious_dv: assert property (@(posedge clk) disable iff (!rst_n)
        (!nib_dv && !line_crs_dv) |=> !nib_dv);

    // R10: low on the closing slot ends the frame without a nibble
    a_r10_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == RX_DATA && rx_q.slot == SLOT_LAST && !line_crs_dv)
        |=> (!nib_dv && !nib_stb));

endmodule

// File: rtl/rmii_mii_bridge.sv
module rmii_mii_bridge #(
    parameter int                MII_W      = 4,
    parameter int                RMII_W     = 2,
    parameter logic [RMII_W-1:0] START_CODE = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mii_tx_stb,
    input  logic              mii_tx_en,
    input  logic [MII_W-1:0]  mii_txd,
    input  logic              mii_tx_er,
    output logic              mii_col,
    output logic              mii_crs,
    output logic              mii_rx_dv,
    output logic [MII_W-1:0]  mii_rxd,
    output logic              mii_rx_stb,
    output logic              rmii_tx_en,
    output logic [RMII_W-1:0] rmii_txd,
    input  logic              rmii_crs_dv,
    input  logic [RMII_W-1:0] rmii_rxd
);
    localparam int RATIO = MII_W / RMII_W;

    logic unused_tx_er;

    assign unused_tx_er = mii_tx_er;
    assign mii_col      = 1'b0;

    rmii_nibble_phase #(
        .RATIO (RATIO)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .nib_stb (mii_tx_stb)
    );

    rmii_tx_serializer #(
        .MII_W  (MII_W),
        .RMII_W (RMII_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_stb   (mii_tx_stb),
        .nib_en    (mii_tx_en),
        .nib_data  (mii_txd),
        .line_en   (rmii_tx_en),
        .line_data (rmii_txd)
    );

    rmii_rx_deserializer #(
        .MII_W      (MII_W),
        .RMII_W     (RMII_W),
        .START_CODE (START_CODE)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_crs_dv (rmii_crs_dv),
        .line_data   (rmii_rxd),
        .nib_crs     (mii_crs),
        .nib_dv      (mii_rx_dv),
        .nib_data    (mii_rxd),
        .nib_stb     (mii_rx_stb)
    );

endmodule

// File: tb/rmii_mii_bridge_bench.sv
module rmii_mii_bridge_bench;
    localparam int CLK_PERIOD = 20;
    localparam int NVEC = 6;
    // {tx_er, tx_en, nibble}
    localparam logic [5:0] TXV [NVEC] = '{
        6'b0_1_0101, 6'b1_1_1101, 6'b0_1_1010,
        6'b1_1_0011, 6'b1_0_1111, 6'b0_1_0000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mii_tx_stb, mii_tx_en, mii_tx_er, mii_col, mii_crs, mii_rx_dv, mii_rx_stb;
    logic [3:0] mii_txd, mii_rxd;
    logic       rmii_tx_en, rmii_crs_dv;
    logic [1:0] rmii_txd, rmii_rxd;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rmii_mii_bridge u_rmii_mii_bridge (
        .clk(clk), .rst_n(rst_n), .mii_tx_stb(mii_tx_stb), .mii_tx_en(mii_tx_en),
        .mii_txd(mii_txd), .mii_tx_er(mii_tx_er), .mii_col(mii_col), .mii_crs(mii_crs),
        .mii_rx_dv(mii_rx_dv), .mii_rxd(mii_rxd), .mii_rx_stb(mii_rx_stb),
        .rmii_tx_en(rmii_tx_en), .rmii_txd(rmii_txd), .rmii_crs_dv(rmii_crs_dv),
        .rmii_rxd(rmii_rxd)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rx_step(input logic dv, input logic [1:0] d);
        rmii_crs_dv = dv;
        rmii_rxd    = d;
        tick();
    endtask

    task automatic rx_nib(input string req, input logic [3:0] nib, input logic dv0, input logic dv1);
        rx_step(dv0, nib[1:0]);
        chk(req, {7'd0, mii_rx_dv}, 8'd1);
        chk(req, {7'd0, mii_rx_stb}, 8'd0);
        rx_step(dv1, nib[3:2]);
        chk(req, {4'd0, mii_rxd}, {4'd0, nib});
        chk(req, {7'd0, mii_rx_stb}, 8'd1);
        chk(req, {7'd0, mii_rx_dv}, 8'd1);
    endtask

    initial begin
        mii_tx_en = 1'b0; mii_txd = 4'h0; mii_tx_er = 1'b0;
        rmii_crs_dv = 1'b0; rmii_rxd = 2'b00;
        tick(); tick();
        // R1: reset state
        chk("R1", {6'd0, rmii_tx_en, mii_rx_dv}, 8'd0);
        chk("R1", {4'd0, rmii_txd, mii_crs, mii_rx_stb}, 8'd0);
        chk("R1", {4'd0, mii_rxd}, 8'd0);
        rst_n = 1'b1;
        tick();
        // R2: strobe alternates
        for (int k = 0; k < 4; k++) begin
            logic s0;
            s0 = mii_tx_stb;
            tick();
            chk("R2", {7'd0, mii_tx_stb}, {7'd0, ~s0});
        end
        if (!mii_tx_stb) tick();
        // R3 R4 R5: transmit vectors
        for (int i = 0; i < NVEC; i++) begin
            mii_tx_er = TXV[i][5];
            mii_tx_en = TXV[i][4];
            mii_txd   = TXV[i][3:0];
            tick();
            chk("R3", {6'd0, rmii_txd}, {6'd0, TXV[i][1:0]});
            chk("R4", {7'd0, rmii_tx_en}, {7'd0, TXV[i][4]});
            chk("R5", {7'd0, mii_col}, 8'd0);
            tick();
            chk("R3", {6'd0, rmii_txd}, {6'd0, TXV[i][3:2]});
            chk("R4", {7'd0, rmii_tx_en}, {7'd0, TXV[i][4]});
            chk("R2", {7'd0, mii_tx_stb}, 8'd1);
        end
        mii_tx_en = 1'b0; mii_tx_er = 1'b1; mii_txd = 4'hF;
        tick();
        chk("R5", {7'd0, rmii_tx_en}, 8'd0);
        tick();
        chk("R4", {7'd0, rmii_tx_en}, 8'd0);
        mii_tx_er = 1'b0;
        // R6: non-preamble dibits with carrier do not start a frame
        rx_step(1'b1, 2'b10);
        chk("R8", {7'd0, mii_crs}, 8'd1);
        chk("R6", {7'd0, mii_rx_dv}, 8'd0);
        rx_step(1'b1, 2'b00);
        chk("R6", {7'd0, mii_rx_dv}, 8'd0);
        rx_step(1'b1, 2'b01);
        chk("R6", {6'd0, mii_rx_dv, mii_rx_stb}, 8'd0);
        rx_step(1'b1, 2'b01);
        chk("R6", {4'd0, mii_rxd}, 8'h05);
        chk("R7", {6'd0, mii_rx_dv, mii_rx_stb}, 8'd3);
        rx_nib("R7", 4'hD, 1'b1, 1'b1);
        rx_nib("R7", 4'hA, 1'b1, 1'b1);
        rx_nib("R7", 4'h3, 1'b1, 1'b1);
        chk("R8", {7'd0, mii_crs}, 8'd1);
        // R9: toggling tail, first dibit low
        rx_step(1'b0, 2'b10);
        chk("R8", {7'd0, mii_crs}, 8'd0);
        chk("R9", {7'd0, mii_rx_dv}, 8'd1);
        rx_step(1'b1, 2'b01);
        chk("R9", {4'd0, mii_rxd}, 8'h06);
        chk("R9", {6'd0, mii_rx_dv, mii_rx_stb}, 8'd3);
        chk("R8", {7'd0, mii_crs}, 8'd0);
        rx_nib("R9", 4'h9, 1'b0, 1'b1);
        chk("R8", {7'd0, mii_crs}, 8'd0);
        // R10: low on both dibits closes the frame
        rx_step(1'b0, 2'b00);
        chk("R9", {7'd0, mii_rx_dv}, 8'd1);
        rx_step(1'b0, 2'b00);
        chk("R10", {6'd0, mii_rx_dv, mii_rx_stb}, 8'd0);
        chk("R10", {4'd0, mii_rxd}, 8'h09);
        rx_step(1'b1, 2'b01);
        chk("R8", {7'd0, mii_crs}, 8'd1);
        rx_step(1'b0, 2'b11);
        chk("R10", {6'd0, mii_rx_dv, mii_rx_stb}, 8'd0);
        chk("R10", {4'd0, mii_rxd}, 8'h09);
        chk("R8", {7'd0, mii_crs}, 8'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule